// File: doc/BRIEF.md
# Word Parity and Write-Protect Guard

This block sits between a processor port and a word-addressed store of 24-bit words. Alongside each word it keeps one parity bit and one protect bit. A processor write arrives with its own bus parity bit. The guard checks that bit. If the bus parity is good and the word is not protected, the guard stores the data together with a freshly generated odd parity bit. On a read it returns the stored word, its parity bit and its protect bit, and it recomputes the parity.

When a check fails, the guard latches the full request address and a cause flag and raises a level interrupt request. The checks that can fail are bad bus parity on a write, bad stored parity on a read, and a write aimed at a protected word. The latched values stay until software clears them, and a further fault in the meantime sets an overflow flag.

Software changes a word's protect bit with a separate command: a write with the protect-select flag set, taking the new value from data bit 0. The array is a parameterised model with a depth set by the `DEPTH` parameter. The address is 15 bits wide so that it can span 32,768 words. A fault-injection input lets a write store inverted parity, which models a corrupted cell.

Top module: `mem_guard`

## Requirements
- R1: After reset every word reads back data 0, parity 1 and protect 0, and `irq_o`, `err_ovf_o` and `rvalid_o` are low.
- R2: A read (`req_i`=1, `we_i`=0) drives `rvalid_o` high in the next cycle only, with `rdata_o`, `rpar_o` and `rprot_o` showing the word as stored. A good write stores odd parity, so that the 24 data bits plus the parity bit hold an odd count of ones.
- R3: A data write (`we_i`=1, `prot_cmd_i`=0) to an unprotected word is good only if `wdata_i` together with `wpar_i` holds an odd count of ones. Otherwise the stored word is left unchanged and a fault with cause 0 (parity) is raised.
- R4: A read of a word whose stored data and parity hold an even count of ones raises a parity fault (cause 0). The read still returns the stored data and parity.
- R5: A protect command (`we_i`=1, `prot_cmd_i`=1) sets the addressed word's protect bit to `wdata_i[0]`. It leaves the data and parity unchanged, skips the bus parity check and never raises a fault.
- R6: A data write to a protected word is suppressed and raises a fault with cause 1 (protect). This holds whatever the bus parity is.
- R7: The first fault while no error is held sets `irq_o`, `err_addr_o` (the full 15-bit request address) and `err_cause_o` at the next clock edge. These values are held from then on.
- R8: A fault while an error is already held leaves `err_addr_o` and `err_cause_o` unchanged and sets `err_ovf_o`.
- R9: `err_clr_i` clears `irq_o` and `err_ovf_o`. A fault in the same cycle as the clear is captured as a new first fault, with overflow low.
- R10: A data write that passes its checks while `inj_flip_i`=1 stores the inverted parity bit.
- R11: The array is indexed by the low log2(`DEPTH`) address bits, so addresses that differ by a multiple of `DEPTH` reach the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| prot_cmd_i | input | 1 | With `we_i`: update the protect bit only |
| addr_i | input | 15 | Word address |
| wdata_i | input | 24 | Write data; bit 0 is the new protect value for a protect command |
| wpar_i | input | 1 | Bus parity bit for `wdata_i` (odd) |
| inj_flip_i | input | 1 | Fault model: store inverted parity on this write |
| err_clr_i | input | 1 | Clear the latched error and overflow |
| rdata_o | output | 24 | Read data, registered |
| rpar_o | output | 1 | Stored parity bit of the word read |
| rprot_o | output | 1 | Protect bit of the word read |
| rvalid_o | output | 1 | Read data valid, one cycle after a read |
| irq_o | output | 1 | Interrupt request, high while an error is held |
| err_addr_o | output | 15 | Address of the first held fault |
| err_cause_o | output | 1 | 0 = parity, 1 = protect |
| err_ovf_o | output | 1 | A further fault arrived while one was held |

## Verification
Directed sequences come first. They write and read good words, then corrupt one word through injection and read it twice to see capture and overflow. They also write with bad bus parity, protect a word and write to it with both good and bad parity to pin the cause priority, clear in the same cycle as a new fault, and reach a word through an aliased address. A seeded random mix of reads, data writes, protect commands, idle cycles and clears follows, over a small address window so that words are hit repeatedly. In that mix, occasional bad bus parity and injection separate write-side from read-side parity faults, and protected words separate suppression from storage. Every cycle is compared with a reference model of the array and of the error latch.

// File: rtl/mem_guard_pkg.sv
package mem_guard_pkg;
  parameter int unsigned WORD_W  = 24;
  parameter int unsigned ADR_W   = 15;
  parameter int unsigned WORDS   = 512;

  typedef enum logic {
    CAUSE_PARITY  = 1'b0,
    CAUSE_PROTECT = 1'b1
  } cause_e;
endpackage

// File: rtl/mem_guard_array.sv
module mem_guard_array #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned DEPTH  = 512,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              data_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              inj_flip_i,
  input  logic              prot_we_i,
  input  logic              prot_val_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_par_o,
  output logic              rd_prot_o
);
  logic [DATA_W-1:0] data_q [DEPTH];
  logic              par_q  [DEPTH];
  logic              prot_q [DEPTH];
  logic              new_par;

  assign new_par = (~^wdata_i) ^ inj_flip_i;

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q[w] <= '0;
        par_q[w]  <= 1'b1;
        prot_q[w] <= 1'b0;
      end else begin
        if (data_we_i && idx_i == IDX_W'(w)) begin
          data_q[w] <= wdata_i;
          par_q[w]  <= new_par;
        end
        if (prot_we_i && idx_i == IDX_W'(w)) prot_q[w] <= prot_val_i;
      end
    end
  end

  assign rd_data_o = data_q[idx_i];
  assign rd_par_o  = par_q[idx_i];
  assign rd_prot_o = prot_q[idx_i];

  // R6: the access decoder must never let a data write reach a protected word
  a_r6_no_write_protected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_we_i |-> !rd_prot_o);
  // R2: clean writes land with odd parity
  a_r2_stored_odd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we_i && !inj_flip_i) |=> (^{data_q[$past(idx_i)], par_q[$past(idx_i)]}) == 1'b1);
  // R5: protect command leaves data untouched
  a_r5_data_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prot_we_i && !data_we_i) |=> data_q[$past(idx_i)] == $past(rd_data_o));
endmodule

// File: rtl/mem_guard_check.sv
module mem_guard_check
  import mem_guard_pkg::*;
#(
  parameter int unsigned DATA_W = 24
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic              prot_cmd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wpar_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              rd_par_i,
  input  logic              rd_prot_i,
  output logic              rd_en_o,
  output logic              data_we_o,
  output logic              prot_we_o,
  output logic              fault_o,
  output cause_e            cause_o
);
  logic wr_data, bus_bad, store_bad, f_prot, f_par_w, f_par_r;

  always_comb begin
    wr_data   = req_i && we_i && !prot_cmd_i;
    rd_en_o   = req_i && !we_i;
    prot_we_o = req_i && we_i && prot_cmd_i;
    bus_bad   = ~(^{wdata_i, wpar_i});
    store_bad = ~(^{rd_data_i, rd_par_i});
    // protect outranks parity on a write
    f_prot    = wr_data && rd_prot_i;
    f_par_w   = wr_data && !rd_prot_i && bus_bad;
    f_par_r   = rd_en_o && store_bad;
    data_we_o = wr_data && !rd_prot_i && !bus_bad;
    fault_o   = f_prot || f_par_w || f_par_r;
    cause_o   = f_prot ? CAUSE_PROTECT : CAUSE_PARITY;
  end
endmodule

// File: rtl/mem_guard_errcap.sv
module mem_guard_errcap
  import mem_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fault_i,
  input  cause_e            cause_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              clr_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output cause_e            cause_o,
  output logic              ovf_o
);
  logic              valid_q, ovf_q;
  logic [ADDR_W-1:0] addr_q;
  cause_e            cause_q;
  logic              held;

  assign held = valid_q && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      ovf_q   <= 1'b0;
      addr_q  <= '0;
      cause_q <= CAUSE_PARITY;
    end else begin
      if (clr_i) begin
        valid_q <= 1'b0;
        ovf_q   <= 1'b0;
      end
      if (fault_i) begin
        if (held) ovf_q <= 1'b1;
        else begin
          valid_q <= 1'b1;
          addr_q  <= addr_i;
          cause_q <= cause_i;
        end
      end
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign cause_o = cause_q;
  assign ovf_o   = ovf_q;

  a_r7_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_i && (!valid_q || clr_i)) |=> (valid_q && addr_q == $past(addr_i) && cause_q == $past(cause_i)));
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !clr_i) |=> ($stable(addr_q) && $stable(cause_q) && valid_q));
  a_r8_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_i && valid_q && !clr_i) |=> ovf_q);
  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !fault_i) |=> (!valid_q && !ovf_q));
endmodule

// File: rtl/mem_guard.sv
module mem_guard
  import mem_guard_pkg::*;
#(
  parameter int unsigned DATA_W = WORD_W,
  parameter int unsigned ADDR_W = ADR_W,
  parameter int unsigned DEPTH  = WORDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              prot_cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wpar_i,
  input  logic              inj_flip_i,
  input  logic              err_clr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rpar_o,
  output logic              rprot_o,
  output logic              rvalid_o,
  output logic              irq_o,
  output logic [ADDR_W-1:0] err_addr_o,
  output logic              err_cause_o,
  output logic              err_ovf_o
);
  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] arr_data;
  logic              arr_par, arr_prot;
  logic              rd_en, data_we, prot_we, fault;
  cause_e            cause, cap_cause;

  assign idx = addr_i[IDX_W-1:0];

  mem_guard_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_array (
    .clk_i, .rst_ni,
    .idx_i      (idx),
    .data_we_i  (data_we),
    .wdata_i,
    .inj_flip_i,
    .prot_we_i  (prot_we),
    .prot_val_i (wdata_i[0]),
    .rd_data_o  (arr_data),
    .rd_par_o   (arr_par),
    .rd_prot_o  (arr_prot)
  );

  mem_guard_check #(.DATA_W(DATA_W)) u_check (
    .req_i, .we_i, .prot_cmd_i, .wdata_i, .wpar_i,
    .rd_data_i (arr_data),
    .rd_par_i  (arr_par),
    .rd_prot_i (arr_prot),
    .rd_en_o   (rd_en),
    .data_we_o (data_we),
    .prot_we_o (prot_we),
    .fault_o   (fault),
    .cause_o   (cause)
  );

  mem_guard_errcap #(.ADDR_W(ADDR_W)) u_errcap (
    .clk_i, .rst_ni,
    .fault_i (fault),
    .cause_i (cause),
    .addr_i,
    .clr_i   (err_clr_i),
    .valid_o (irq_o),
    .addr_o  (err_addr_o),
    .cause_o (cap_cause),
    .ovf_o   (err_ovf_o)
  );

  assign err_cause_o = cap_cause;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rpar_o   <= 1'b1;
      rprot_o  <= 1'b0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_en;
      if (rd_en) begin
        rdata_o <= arr_data;
        rpar_o  <= arr_par;
        rprot_o <= arr_prot;
      end
    end
  end

  a_r5_cmd_no_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && prot_cmd_i) |-> !fault);
  a_r2_rvalid_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);
  a_r2_no_rvalid_otherwise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);
endmodule

// File: tb/mem_guard_tb_top.sv
module mem_guard_tb_top;
  localparam int DW = 24;
  localparam int AW = 15;
  localparam int DEP = 512;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, we = 0, pc = 0, wpar = 0, inj = 0, clr = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rpar, rprot, rvalid, irq, ecause, eovf;
  logic [AW-1:0] eaddr;

  always #4 clk = ~clk;

  mem_guard dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .prot_cmd_i(pc),
    .addr_i(addr), .wdata_i(wdata), .wpar_i(wpar), .inj_flip_i(inj),
    .err_clr_i(clr), .rdata_o(rdata), .rpar_o(rpar), .rprot_o(rprot),
    .rvalid_o(rvalid), .irq_o(irq), .err_addr_o(eaddr), .err_cause_o(ecause),
    .err_ovf_o(eovf)
  );

  logic [DW-1:0] m_data [DEP];
  logic m_par [DEP];
  logic m_prot [DEP];
  logic e_v = 0, e_o = 0, e_c = 0;
  logic [AW-1:0] e_a = '0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  function automatic logic good_par(input logic [DW-1:0] d);
    return ~^d;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_op(input bit r, input bit w, input bit p, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input bit bad_bus, input bit fl,
                       input bit c, input string tag);
    int i;
    bit f, fc, is_rd;
    logic [DW-1:0] xd;
    logic xp, xr;
    @(negedge clk);
    req = r; we = w; pc = p; addr = a; wdata = d;
    wpar = good_par(d) ^ bad_bus; inj = fl; clr = c;
    i = int'(a) % DEP;
    f = 0; fc = 0; is_rd = r && !w;
    xd = m_data[i]; xp = m_par[i]; xr = m_prot[i];
    if (r && w && p) m_prot[i] = d[0];
    else if (r && w) begin
      if (m_prot[i]) begin f = 1; fc = 1; end
      else if (bad_bus) begin f = 1; fc = 0; end
      else begin m_data[i] = d; m_par[i] = good_par(d) ^ fl; end
    end else if (r) begin
      if ((^{xd, xp}) != 1'b1) begin f = 1; fc = 0; end
    end
    @(posedge clk);
    if (c) begin e_v = 0; e_o = 0; end
    if (f) begin
      if (e_v) e_o = 1;
      else begin e_v = 1; e_a = a; e_c = fc; end
    end
    @(negedge clk);
    req = 0; we = 0; pc = 0; inj = 0; clr = 0;
    chk(rvalid == is_rd, {tag, " R2 rvalid"}, rvalid, is_rd);
    if (is_rd) begin
      chk(rdata == xd, {tag, " R2 rdata"}, rdata, xd);
      chk(rpar == xp, {tag, " R2 rpar"}, rpar, xp);
      chk(rprot == xr, {tag, " R5 rprot"}, rprot, xr);
    end
    chk(irq == e_v, {tag, " R7 irq"}, irq, e_v);
    chk(eovf == e_o, {tag, " R8 ovf"}, eovf, e_o);
    if (e_v) begin
      chk(eaddr == e_a, {tag, " R7 addr"}, eaddr, e_a);
      chk(ecause == e_c, {tag, " R7 cause"}, ecause, e_c);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string t);
    do_op(1, 1, 0, a, d, 0, 0, 0, t);
  endtask
  task automatic rd(input logic [AW-1:0] a, input string t);
    do_op(1, 0, 0, a, '0, 0, 0, 0, t);
  endtask
  task automatic clear(input string t);
    do_op(0, 0, 0, '0, '0, 0, 0, 1, t);
  endtask

  initial begin
    for (int k = 0; k < DEP; k++) begin m_data[k] = '0; m_par[k] = 1'b1; m_prot[k] = 1'b0; end
    void'($urandom(32'd20211214));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq == 0 && eovf == 0 && rvalid == 0, "R1 reset outputs", {irq, eovf, rvalid}, 0);
    rd(0, "R1 word0");
    rd(DEP - 1, "R1 last word");
    rd(5, "R1 word5");
    wr(10, 24'hABCDEF, "R2 good write");
    rd(10, "R2 readback");
    wr(11, 24'h123456, "R2 second write");
    rd(11, "R2 readback2");
    do_op(1, 1, 0, 12, 24'h00F00F, 0, 1, 0, "R10 inject");
    rd(12, "R4 parity fault read");
    rd(12, "R8 overflow read");
    clear("R9 clear");
    do_op(1, 1, 0, 14, 24'h777777, 1, 0, 0, "R3 bad bus parity");
    rd(14, "R3 word unchanged");
    clear("R9 clear2");
    do_op(1, 1, 1, 13, 24'h000001, 0, 0, 0, "R5 set protect");
    rd(13, "R5 protect visible");
    wr(13, 24'h555555, "R6 protected write");
    rd(13, "R6 data kept");
    clear("R9 clear3");
    do_op(1, 1, 0, 13, 24'h0000AA, 1, 0, 0, "R6 protect over parity");
    do_op(1, 1, 0, 13, 24'h0000AB, 0, 0, 1, "R9 clear with fault");
    do_op(1, 1, 1, 13, 24'h000000, 1, 0, 0, "R5 clear protect bad bus");
    clear("R9 clear4");
    wr(13, 24'h0C0FFE, "R5 write after unprotect");
    rd(13, "R5 readback");
    wr(AW'(20 + DEP), 24'h3A3A3A, "R11 aliased write");
    rd(20, "R11 aliased read");
    rd(AW'(20 + 2 * DEP), "R11 aliased read2");
    for (int n = 0; n < 600; n++) begin
      int sel;
      logic [AW-1:0] ra;
      logic [DW-1:0] rdat;
      bit bb, fl, cl;
      sel = int'($urandom % 10);
      ra = AW'(($urandom % 24) + (($urandom % 4 == 0) ? DEP : 0));
      rdat = DW'($urandom);
      bb = ($urandom % 8) == 0;
      fl = ($urandom % 10) == 0;
      cl = ($urandom % 7) == 0;
      case (sel)
        0, 1, 2, 3: do_op(1, 1, 0, ra, rdat, bb, fl, cl, "R3 rand write");
        4, 5, 6:    do_op(1, 0, 0, ra, rdat, 0, 0, cl, "R4 rand read");
        7:          do_op(1, 1, 1, ra, DW'($urandom % 4 == 0), bb, 0, cl, "R5 rand prot");
        default:    do_op(0, 0, 0, ra, rdat, 0, 0, cl, "R9 rand idle");
      endcase
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule